// File: doc/BRIEF.md
# Precise Exception Ordering Tracker

This block is the exception-ordering controller of a five-stage, in-order integer pipeline. It owns the fetch address. It also keeps a small record for every instruction in flight: a valid bit, the instruction's PC and a four-bit status vector. The records move through the fetch/decode, decode/execute, execute/memory and memory/writeback slots in lock step. The pipeline's stage logic is outside this block. Each stage reports a fault for the instruction it currently holds on a one-bit input, and that bit is ORed into the instruction's status vector at the next slot boundary.

A fault is never acted on when it is raised. The status vector is examined only when the instruction leaves the memory stage. A younger instruction that faults early is therefore always overtaken by an older instruction's late fault. When a fault is committed, the block does five things:
- It blocks the faulting instruction's store and write-back.
- It clears every younger slot in that same cycle.
- It sends fetch to a fixed trap address.
- It records the faulting PC and a cause code.
- It enters a trap state.

An external interrupt request is sampled every cycle. A trap-return strobe sends fetch back to the recorded PC.

Top module: `precise_trap_unit`

## Requirements
- R1: After reset, fetchPc equals RESET_PC, retireValid, trapTaken and trapActive are 0, and savedCause is 0.
- R2: With no trap or return, fetchPc advances by PC_STEP each cycle. An instruction fetched in cycle n shows up on retirePc with retireValid high in cycle n+4. memStoreEn is high while an unfaulted instruction is in the memory stage.
- R3: Faults are resolved only when an instruction leaves the memory stage, and in program order. A memory fault on instruction i is committed with i's PC even if instruction i+1 raised a fetch fault in an earlier cycle.
- R4: In the commit cycle of a fault, memStoreEn is 0 and the faulting instruction never retires. The instruction one older retires normally in that same cycle.
- R5: A commit clears all younger slots in the commit cycle, so retireValid stays 0 for the four cycles that follow an exception.
- R6: In the cycle after trapTaken, fetchPc equals TRAP_PC and trapActive is 1. savedPc holds the faulting (or interrupted) PC.
- R7: savedCause encoding: 1 fetch fault, 2 decode fault, 3 execute fault, 4 memory fault, 5 interrupt. When one instruction carries several faults, the earliest stage's code is recorded.
- R8: With trapActive 0, irqReq takes a trap in the same cycle. The instruction in the memory stage completes and retires. savedPc is the oldest instruction that did not complete, and savedCause is 5.
- R9: While trapActive is 1, irqReq has no effect: fetchPc keeps advancing and trapTaken stays 0.
- R10: If a fault commit and an interrupt fall in the same cycle, the fault wins: savedCause is the fault's code and savedPc is the faulting PC.
- R11: trapReturn without a simultaneous trap loads fetchPc with savedPc in the next cycle and clears trapActive. A fault commit during trapActive is still taken.
- R12: A fault input for a stage that holds no valid instruction is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ifFault | input | 1 | Fault on the instruction being fetched |
| idFault | input | 1 | Fault on the instruction in decode |
| exFault | input | 1 | Fault on the instruction in execute |
| memFault | input | 1 | Fault on the instruction in the memory stage |
| irqReq | input | 1 | Level interrupt request |
| trapReturn | input | 1 | Return-from-trap strobe |
| fetchPc | output | PC_W | Current fetch address |
| memStoreEn | output | 1 | Store permitted for the memory-stage instruction |
| retireValid | output | 1 | Write-back slot holds an instruction that commits |
| retirePc | output | PC_W | PC of the instruction in write-back |
| trapTaken | output | 1 | A trap is committed this cycle |
| trapActive | output | 1 | Handler running; interrupts masked |
| savedPc | output | PC_W | PC recorded at the last trap |
| savedCause | output | 3 | Cause code recorded at the last trap |

## Verification
Two things can land in one cycle: a fault commit at the memory-stage exit and an interrupt request. The bench asserts irqReq in exactly the cycle where a memory fault is committed. It then checks that the recorded cause and PC belong to the fault, not to the interrupt. Because the interrupt is still held high, the bench also checks the following cycle: the trap state must mask the interrupt, so fetch advances from the trap address instead of trapping again.

// File: rtl/ptrk_pkg.sv
package ptrk_pkg;

  localparam int STAGE_N = 4;
  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_FETCH  = 3'd1,
    CAUSE_DECODE = 3'd2,
    CAUSE_EXEC   = 3'd3,
    CAUSE_MEMORY = 3'd4,
    CAUSE_IRQ    = 3'd5
  } cause_e;

  typedef struct packed {
    logic takeExc;
    logic takeIrq;
    logic doReturn;
    logic flushYoung;
  } ctrl_strobe_t;

  // Lowest set bit (earliest stage) decides the code.
  function automatic cause_e firstCause(input logic [STAGE_N-1:0] vec);
    cause_e c;
    c = CAUSE_NONE;
    for (int i = STAGE_N - 1; i >= 0; i--) begin
      if (vec[i]) c = cause_e'(CAUSE_W'(i + 1));
    end
    return c;
  endfunction

endpackage

// File: rtl/ptrk_ctrl.sv
module ptrk_ctrl
  import ptrk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               memCheckValid,
  input  logic [STAGE_N-1:0] memCheckVec,
  input  logic               irqReq,
  input  logic               trapReturn,
  output ctrl_strobe_t       strobe,
  output logic               trapActive
);

  logic excNow;
  logic irqNow;
  logic retNow;

  always_comb begin
    excNow = memCheckValid && (|memCheckVec);
    irqNow = irqReq && !trapActive && !excNow;
    retNow = trapReturn && !excNow && !irqNow;
    strobe.takeExc    = excNow;
    strobe.takeIrq    = irqNow;
    strobe.doReturn   = retNow;
    strobe.flushYoung = excNow || irqNow || retNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapActive <= 1'b0;
    end else if (excNow || irqNow) begin
      trapActive <= 1'b1;
    end else if (retNow) begin
      trapActive <= 1'b0;
    end
  end

endmodule

// File: rtl/ptrk_datapath.sv
module ptrk_datapath
  import ptrk_pkg::*;
#(
  parameter int          PC_W     = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_0100,
  parameter logic [31:0] TRAP_PC  = 32'h0000_0080,
  parameter int          PC_STEP  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ifFault,
  input  logic               idFault,
  input  logic               exFault,
  input  logic               memFault,
  input  ctrl_strobe_t       strobe,
  output logic               memCheckValid,
  output logic [STAGE_N-1:0] memCheckVec,
  output logic [PC_W-1:0]    fetchPc,
  output logic               memStoreEn,
  output logic               retireValid,
  output logic [PC_W-1:0]    retirePc,
  output logic [PC_W-1:0]    savedPc,
  output logic [CAUSE_W-1:0] savedCause
);

  localparam int MEM_SLOT = STAGE_N - 2;
  localparam int WB_SLOT  = STAGE_N - 1;
  localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

  // slot 0: fetch/decode, 1: decode/exec, 2: exec/mem, 3: mem/writeback
  logic               slotValid [STAGE_N];
  logic [PC_W-1:0]    slotPc    [STAGE_N];
  logic [STAGE_N-1:0] slotStat  [STAGE_N];

  logic               srcValid  [STAGE_N];
  logic [PC_W-1:0]    srcPc     [STAGE_N];
  logic [STAGE_N-1:0] srcStat   [STAGE_N];
  logic [STAGE_N-1:0] nextStat  [STAGE_N];
  logic               killSlot  [STAGE_N];

  logic [STAGE_N-1:0] stageFault;
  assign stageFault = {memFault, exFault, idFault, ifFault};

  for (genvar g = 0; g < STAGE_N; g++) begin : gSlot
    if (g == 0) begin : gHead
      assign srcValid[g] = 1'b1;
      assign srcPc[g]    = fetchPc;
      assign srcStat[g]  = '0;
    end else begin : gBody
      assign srcValid[g] = slotValid[g-1];
      assign srcPc[g]    = slotPc[g-1];
      assign srcStat[g]  = slotStat[g-1];
    end

    assign nextStat[g] = srcStat[g] |
      ((srcValid[g] && stageFault[g]) ? STAGE_N'(1) << g : '0);

    if (g == WB_SLOT) begin : gWbKill
      assign killSlot[g] = strobe.takeExc;
    end else begin : gYoungKill
      assign killSlot[g] = strobe.flushYoung;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[g] <= 1'b0;
        slotPc[g]    <= '0;
        slotStat[g]  <= '0;
      end else begin
        slotValid[g] <= srcValid[g] && !killSlot[g];
        slotPc[g]    <= srcPc[g];
        slotStat[g]  <= nextStat[g];
      end
    end
  end

  assign memCheckValid = slotValid[MEM_SLOT];
  assign memCheckVec   = nextStat[WB_SLOT];
  assign memStoreEn    = slotValid[MEM_SLOT] && !(|memCheckVec);
  assign retireValid   = slotValid[WB_SLOT];
  assign retirePc      = slotPc[WB_SLOT];

  // Oldest instruction that will not complete when an interrupt is taken.
  logic [PC_W-1:0] irqPc;
  always_comb begin
    if (slotValid[1])      irqPc = slotPc[1];
    else if (slotValid[0]) irqPc = slotPc[0];
    else                   irqPc = fetchPc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchPc    <= RESET_PC[PC_W-1:0];
      savedPc    <= '0;
      savedCause <= CAUSE_NONE;
    end else begin
      if (strobe.takeExc || strobe.takeIrq) fetchPc <= TRAP_PC[PC_W-1:0];
      else if (strobe.doReturn)             fetchPc <= savedPc;
      else                                  fetchPc <= fetchPc + STEP_V;

      if (strobe.takeExc) begin
        savedPc    <= slotPc[MEM_SLOT];
        savedCause <= firstCause(memCheckVec);
      end else if (strobe.takeIrq) begin
        savedPc    <= irqPc;
        savedCause <= CAUSE_IRQ;
      end
    end
  end

endmodule

// File: rtl/precise_trap_unit.sv
module precise_trap_unit
  import ptrk_pkg::*;
#(
  parameter int          PC_W     = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_0100,
  parameter logic [31:0] TRAP_PC  = 32'h0000_0080,
  parameter int          PC_STEP  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ifFault,
  input  logic            idFault,
  input  logic            exFault,
  input  logic            memFault,
  input  logic            irqReq,
  input  logic            trapReturn,
  output logic [PC_W-1:0] fetchPc,
  output logic            memStoreEn,
  output logic            retireValid,
  output logic [PC_W-1:0] retirePc,
  output logic            trapTaken,
  output logic            trapActive,
  output logic [PC_W-1:0] savedPc,
  output logic [2:0]      savedCause
);

  ctrl_strobe_t       strobe;
  logic               memCheckValid;
  logic [STAGE_N-1:0] memCheckVec;

  ptrk_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .memCheckValid(memCheckValid),
    .memCheckVec  (memCheckVec),
    .irqReq       (irqReq),
    .trapReturn   (trapReturn),
    .strobe       (strobe),
    .trapActive   (trapActive)
  );

  ptrk_datapath #(
    .PC_W    (PC_W),
    .RESET_PC(RESET_PC),
    .TRAP_PC (TRAP_PC),
    .PC_STEP (PC_STEP)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .ifFault      (ifFault),
    .idFault      (idFault),
    .exFault      (exFault),
    .memFault     (memFault),
    .strobe       (strobe),
    .memCheckValid(memCheckValid),
    .memCheckVec  (memCheckVec),
    .fetchPc      (fetchPc),
    .memStoreEn   (memStoreEn),
    .retireValid  (retireValid),
    .retirePc     (retirePc),
    .savedPc      (savedPc),
    .savedCause   (savedCause)
  );

  assign trapTaken = strobe.takeExc || strobe.takeIrq;

endmodule

// File: rtl/precise_trap_unit_chk.sv
module precise_trap_unit_chk #(
  parameter int          PC_W     = 32,
  parameter logic [31:0] TRAP_PC  = 32'h0000_0080,
  parameter int          PC_STEP  = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            memFault,
  input logic            trapReturn,
  input logic [PC_W-1:0] fetchPc,
  input logic            memStoreEn,
  input logic            trapTaken,
  input logic            trapActive,
  input logic [PC_W-1:0] savedPc,
  input logic [2:0]      savedCause
);

  assert_seq_fetch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!trapTaken && !trapReturn) |=> fetchPc == $past(fetchPc) + PC_W'(PC_STEP));

  assert_store_block_R4: assert property (@(posedge clk) disable iff (!rstN)
    memFault |-> !memStoreEn);

  assert_flush_young_R5: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |=> !trapTaken);

  assert_redirect_R6: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |=> (fetchPc == TRAP_PC[PC_W-1:0]) && trapActive);

  assert_cause_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |=> savedCause != 3'd0);

  assert_hold_trap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (trapActive && !trapReturn) |=> trapActive);

  assert_return_R11: assert property (@(posedge clk) disable iff (!rstN)
    (trapReturn && !trapTaken) |=> (fetchPc == $past(savedPc)) && !trapActive);

endmodule

bind precise_trap_unit precise_trap_unit_chk #(
  .PC_W   (PC_W),
  .TRAP_PC(TRAP_PC),
  .PC_STEP(PC_STEP)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .memFault  (memFault),
  .trapReturn(trapReturn),
  .fetchPc   (fetchPc),
  .memStoreEn(memStoreEn),
  .trapTaken (trapTaken),
  .trapActive(trapActive),
  .savedPc   (savedPc),
  .savedCause(savedCause)
);

// File: tb/precise_trap_unit_tb.sv
module precise_trap_unit_tb_top;

  localparam int          PC_W  = 32;
  localparam logic [31:0] RST_A = 32'h0000_0100;
  localparam logic [31:0] TRP_A = 32'h0000_0080;

  logic clk = 1'b0;
  logic rstN;
  logic ifFault, idFault, exFault, memFault, irqReq, trapReturn;
  logic [PC_W-1:0] fetchPc, retirePc, savedPc;
  logic memStoreEn, retireValid, trapTaken, trapActive;
  logic [2:0] savedCause;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  precise_trap_unit #(.PC_W(PC_W), .RESET_PC(RST_A), .TRAP_PC(TRP_A), .PC_STEP(4)) dut_i (
    .clk(clk), .rstN(rstN), .ifFault(ifFault), .idFault(idFault), .exFault(exFault),
    .memFault(memFault), .irqReq(irqReq), .trapReturn(trapReturn), .fetchPc(fetchPc),
    .memStoreEn(memStoreEn), .retireValid(retireValid), .retirePc(retirePc),
    .trapTaken(trapTaken), .trapActive(trapActive), .savedPc(savedPc), .savedCause(savedCause)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    ifFault = 0; idFault = 0; exFault = 0; memFault = 0; irqReq = 0; trapReturn = 0;
  endtask

  // Advance to the next negative edge, then let combinational outputs settle.
  task automatic step();
    @(negedge clk);
    clearIn();
    #1;
  endtask

  // Leaves the bench at cycle 0: one negedge after release, nothing fetched yet.
  task automatic doReset();
    clearIn();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
  endtask

  task automatic tReset();
    doReset();
    check("R1 fetchPc", fetchPc, RST_A);
    check("R1 retireValid", retireValid, 0);
    check("R1 trapTaken", trapTaken, 0);
    check("R1 trapActive", trapActive, 0);
    check("R1 savedCause", savedCause, 0);
  endtask

  task automatic tFlow();
    doReset();
    for (int n = 1; n <= 6; n++) begin
      step();
      check("R2 fetch advance", fetchPc, RST_A + 4 * n);
      if (n >= 3) check("R2 store enable", memStoreEn, 1);
      if (n >= 4) begin
        check("R2 retireValid", retireValid, 1);
        check("R2 retirePc", retirePc, RST_A + 4 * (n - 4));
      end else begin
        check("R2 no early retire", retireValid, 0);
      end
    end
  endtask

  task automatic tOrder();
    doReset();
    step(); step(); step();
    ifFault = 1; #1;                     // n=3: younger 0x10c fetch fault
    step(); step();                      // n=5: 0x108 in memory stage
    memFault = 1; #1;
    check("R3 trap at memory exit", trapTaken, 1);
    check("R4 store blocked", memStoreEn, 0);
    check("R4 older retires", retireValid, 1);
    check("R4 older retirePc", retirePc, RST_A + 4);
    step();                              // n=6
    check("R6 redirect", fetchPc, TRP_A);
    check("R3 savedPc is older", savedPc, RST_A + 8);
    check("R3 cause is memory", savedCause, 4);
    check("R6 trapActive", trapActive, 1);
    for (int k = 0; k < 4; k++) begin
      check("R5 flushed slot", retireValid, 0);
      check("R5 no retrap", trapTaken, 0);
      step();
    end
    check("R5 trap fetch retires", retireValid, 1);
    check("R5 trap retirePc", retirePc, TRP_A);
  endtask

  task automatic tMultiCause();
    doReset();
    memFault = 1; #1;                    // n=0: memory slot empty
    check("R12 invalid slot fault", trapTaken, 0);
    step();
    check("R12 fetch undisturbed", fetchPc, RST_A + 4);
    ifFault = 1; #1;                     // n=1 on 0x104
    step(); step();
    exFault = 1; #1;                     // n=3 on 0x104
    step();                              // n=4 commit
    check("R7 commit", trapTaken, 1);
    step();
    check("R7 earliest cause", savedCause, 1);
    check("R7 savedPc", savedPc, RST_A + 4);
  endtask

  task automatic tIrqReturn();
    doReset();
    for (int k = 0; k < 6; k++) step();  // n=6
    irqReq = 1; #1;
    check("R8 irq taken", trapTaken, 1);
    check("R8 memory stage store kept", memStoreEn, 1);
    @(negedge clk); irqReq = 1; #1;      // n=7, irq held
    check("R8 redirect", fetchPc, TRP_A);
    check("R8 savedPc oldest pending", savedPc, RST_A + 16);
    check("R8 cause irq", savedCause, 5);
    check("R8 memory instr retires", retirePc, RST_A + 12);
    check("R8 retireValid", retireValid, 1);
    check("R9 masked", trapTaken, 0);
    @(negedge clk); irqReq = 1; #1;      // n=8
    check("R9 fetch advances", fetchPc, TRP_A + 4);
    check("R9 still masked", trapTaken, 0);
    step();                              // n=9
    trapReturn = 1; #1;
    step();                              // n=10
    check("R11 restore pc", fetchPc, RST_A + 16);
    check("R11 trap cleared", trapActive, 0);
    for (int k = 0; k < 4; k++) step();  // n=14
    check("R11 resumed retire", retirePc, RST_A + 16);
    check("R11 resumed valid", retireValid, 1);
  endtask

  task automatic tCollide();
    doReset();
    for (int k = 0; k < 4; k++) step();  // n=4: 0x104 in memory stage
    memFault = 1; irqReq = 1; #1;
    check("R10 trap", trapTaken, 1);
    @(negedge clk); irqReq = 1; #1;      // n=5
    check("R10 fault cause wins", savedCause, 4);
    check("R10 fault pc wins", savedPc, RST_A + 4);
    @(negedge clk); irqReq = 1; #1;      // n=6
    check("R9 no irq retrap", fetchPc, TRP_A + 4);
    step(); step();                      // n=8: trap instr in memory stage
    memFault = 1; #1;
    check("R11 fault inside handler", trapTaken, 1);
    step();
    check("R11 handler fault pc", savedPc, TRP_A);
    check("R11 handler redirect", fetchPc, TRP_A);
  endtask

  initial begin
    clearIn();
    rstN = 0;
    tReset();
    tFlow();
    tOrder();
    tMultiCause();
    tIrqReturn();
    tCollide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule